// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 peripheral interrupt request lines and presents one of them at a time to a processor. Each line holds a pending flag, an enable flag and a 2-bit priority. Software reaches all of this state through a small word-addressed register port. Enable and pending state each have a pair of write-one-to-set and write-one-to-clear words. The priorities are packed four lines per word across eight words. Software can also raise or drop a pending flag directly.

The arbiter looks at every line that is both pending and enabled. It picks the one with the numerically lowest priority value, and breaks ties in favour of the lower line number. It then drives that line's index together with a valid flag. The processor accepts the line with `irq_ack`. That marks it active and clears its pending flag. The processor later retires it with `irq_done`. A line is offered while a handler runs only if its priority is strictly above the level of the innermost active handler. With four levels, nesting never goes deeper than four.

The selection is computed from the current register state in the same cycle. A higher-priority request that arrives before the acknowledge therefore replaces the offered line as soon as its pending flag is set.

Top module: `intc_top`

## Requirements
- R1: A high level on `irq_req[i]` at a rising clock edge leaves pending bit i set after that edge. Pending state reads back at word address 2 and at word address 3, bit i for line i.
- R2: A write to address 2 sets every pending bit whose data bit is one. A write to address 3 clears every pending bit whose data bit is one. Zero data bits leave their pending bits unchanged.
- R3: Enable bits use address 0 for write-one-to-set and address 1 for write-one-to-clear. Zero data bits have no effect, and both addresses read back the current enable bits.
- R4: Priority word 8+k holds lines 4k..4k+3. Line 4k+b keeps its 2-bit priority in bits [8b+7:8b+6]. All other bits of a priority word read as zero, and writes to them are dropped.
- R5: `irq_valid` is high only when some line is both pending and enabled. `irq_id` names the line with the smallest priority value, and the lower line number wins on a tie. A pending line whose enable bit is clear is never offered.
- R6: When a request with a better priority becomes pending before the acknowledge, `irq_id` switches to it in the cycle after its request edge.
- R7: `irq_ack` while `irq_valid` is high clears the pending bit of the offered line at that edge and makes the line active. An acknowledge while `irq_valid` is low has no effect.
- R8: While a handler is active, `irq_valid` stays low unless a pending, enabled line has a priority value strictly smaller than the active level. An equal level never preempts.
- R9: `irq_done` retires the innermost active line. The next outer handler's level then governs preemption, and when none is left every pending, enabled line may be offered again.
- R10: A request still high when its pending bit is cleared by software sets the bit again at the next clock edge.
- R11: After reset all pending, enable and priority state reads zero and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 32 | Request level from each peripheral line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_valid | output | 1 | A line is offered to the processor |
| irq_id | output | 5 | Index of the offered line |
| irq_ack | input | 1 | Processor accepts the offered line |
| irq_done | input | 1 | Processor retires the innermost active line |

## Verification
The bound checker watches on every cycle that an offered line is pending and enabled, and that it beats the active level strictly. It also checks that requests and acknowledges move the pending bits as required, that retirement shrinks the nesting depth by one, and that reserved priority bits read zero. Only the directed scenarios show which line wins among several candidates: ties, late arrivals, masking by enable, the order of resumption after nested handlers, and the re-pend of a held request after a software clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned LINES    = 32;
   localparam int unsigned PRIO_W   = 2;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned ADDR_W   = 4;

   localparam logic [ADDR_W-1:0] A_EN_SET = 4'd0;
   localparam logic [ADDR_W-1:0] A_EN_CLR = 4'd1;
   localparam logic [ADDR_W-1:0] A_PD_SET = 4'd2;
   localparam logic [ADDR_W-1:0] A_PD_CLR = 4'd3;
   localparam logic [ADDR_W-1:0] A_PRIO0  = 4'd8;
endpackage

// File: rtl/intc_w1_bank.sv
module intc_w1_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_mask,
   input  logic [W-1:0] clr_mask,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] state
);
   logic [W-1:0] state_n;

   // clear wins over any set arriving in the same cycle
   always_comb state_n = (state | set_mask | hw_set) & ~clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= '0;
      else        state <= state_n;
   end
endmodule

// File: rtl/intc_prio_file.sv
module intc_prio_file #(
   parameter int unsigned N      = 32,
   parameter int unsigned PW     = 2,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned NWORDS = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NWORDS-1:0]         word_we,
   input  logic [WORD_W-1:0]         wdata,
   output logic [N*PW-1:0]           prio_flat,
   output logic [NWORDS*WORD_W-1:0]  words_rd
);
   localparam int unsigned LANE_W = WORD_W / 4;
   localparam int unsigned PAD_W  = LANE_W - PW;

   if (PW > LANE_W) begin : g_bad_pw
      $error("priority width exceeds lane width");
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      localparam int unsigned WD = i / 4;
      localparam int unsigned LN = i % 4;
      logic [PW-1:0] fld;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          fld <= '0;
         else if (word_we[WD]) fld <= wdata[LN*LANE_W+LANE_W-1 -: PW];
      end

      assign prio_flat[i*PW +: PW] = fld;
      assign words_rd[WD*WORD_W + LN*LANE_W +: LANE_W] = {fld, {PAD_W{1'b0}}};
   end
endmodule

// File: rtl/intc_select.sv
module intc_select #(
   parameter int unsigned N   = 32,
   parameter int unsigned PW  = 2,
   parameter int unsigned IDW = 5
) (
   input  logic [N-1:0]    cand,
   input  logic [N*PW-1:0] prio_flat,
   output logic            found,
   output logic [IDW-1:0]  win_id,
   output logic [PW-1:0]   win_prio
);
   // strict compare in ascending index order keeps the lower index on ties
   always_comb begin
      found    = 1'b0;
      win_id   = '0;
      win_prio = '1;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (!found || prio_flat[i*PW +: PW] < win_prio)) begin
            found    = 1'b1;
            win_id   = IDW'(i);
            win_prio = prio_flat[i*PW +: PW];
         end
      end
   end
endmodule

// File: rtl/intc_nest_stack.sv
module intc_nest_stack #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned IDW   = 5,
   parameter int unsigned PW    = 2,
   parameter int unsigned CW    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic [IDW-1:0] push_id,
   input  logic [PW-1:0]  push_prio,
   input  logic           pop,
   output logic [CW-1:0]  depth,
   output logic [PW-1:0]  top_prio
);
   logic [PW-1:0]  lvl_q [DEPTH];
   logic [IDW-1:0] id_q  [DEPTH];
   logic           pop_ok;
   logic           push_ok;
   logic [CW-1:0]  base;

   assign pop_ok  = pop && (depth != '0);
   assign base    = depth - CW'(pop_ok);
   assign push_ok = push && (base < CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            lvl_q[k] <= '0;
            id_q[k]  <= '0;
         end
      end else begin
         depth <= base + CW'(push_ok);
         if (push_ok) begin
            lvl_q[base[$clog2(DEPTH)-1:0]] <= push_prio;
            id_q[base[$clog2(DEPTH)-1:0]]  <= push_id;
         end
      end
   end

   always_comb begin
      top_prio = '1;
      for (int k = 0; k < DEPTH; k++)
         if (CW'(k + 1) == depth) top_prio = lvl_q[k];
   end
endmodule

// File: rtl/intc_top.sv
module intc_top
   import intc_pkg::*;
#(
   parameter int unsigned N      = LINES,
   parameter int unsigned PW     = PRIO_W,
   parameter int unsigned AW     = ADDR_W,
   parameter int unsigned DW     = WORD_W,
   localparam int unsigned IDW    = $clog2(N),
   localparam int unsigned NWORDS = N / 4,
   localparam int unsigned DEPTH  = 1 << PW,
   localparam int unsigned CW     = $clog2(DEPTH) + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   irq_req,
   input  logic           reg_wr,
   input  logic [AW-1:0]  reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic           irq_valid,
   output logic [IDW-1:0] irq_id,
   input  logic           irq_ack,
   input  logic           irq_done
);
   if (N > DW || (N % 4) != 0 || N < 4) begin : g_bad_n
      $error("line count must be a multiple of 4 and fit a data word");
   end
   if (NWORDS + 32'(A_PRIO0) > (1 << AW)) begin : g_bad_aw
      $error("address width too small for priority words");
   end

   logic [N-1:0]           en_q, pd_q;
   logic [N-1:0]           en_set, en_clr, pd_set, pd_clr, ack_mask;
   logic [NWORDS-1:0]      prio_we;
   logic [N*PW-1:0]        prio_flat;
   logic [NWORDS*DW-1:0]   prio_words;
   logic                   found;
   logic [IDW-1:0]         win_id;
   logic [PW-1:0]          win_prio;
   logic [CW-1:0]          act_depth;
   logic [PW-1:0]          act_prio;
   logic                   ack_ok;

   // register write decode
   always_comb begin
      en_set = (reg_wr && reg_addr == A_EN_SET) ? reg_wdata[N-1:0] : '0;
      en_clr = (reg_wr && reg_addr == A_EN_CLR) ? reg_wdata[N-1:0] : '0;
      pd_set = (reg_wr && reg_addr == A_PD_SET) ? reg_wdata[N-1:0] : '0;
      pd_clr = (reg_wr && reg_addr == A_PD_CLR) ? reg_wdata[N-1:0] : '0;
      for (int k = 0; k < NWORDS; k++)
         prio_we[k] = reg_wr && (reg_addr == AW'(32'(A_PRIO0) + k));
   end

   assign ack_ok   = irq_ack && irq_valid;
   assign ack_mask = ack_ok ? (N'(1) << irq_id) : '0;

   intc_w1_bank #(.W(N)) u_enable (
      .clk(clk), .rst_n(rst_n),
      .set_mask(en_set), .clr_mask(en_clr), .hw_set('0), .state(en_q)
   );

   intc_w1_bank #(.W(N)) u_pending (
      .clk(clk), .rst_n(rst_n),
      .set_mask(pd_set), .clr_mask(pd_clr | ack_mask), .hw_set(irq_req),
      .state(pd_q)
   );

   intc_prio_file #(.N(N), .PW(PW), .WORD_W(DW), .NWORDS(NWORDS)) u_prio (
      .clk(clk), .rst_n(rst_n), .word_we(prio_we), .wdata(reg_wdata),
      .prio_flat(prio_flat), .words_rd(prio_words)
   );

   intc_select #(.N(N), .PW(PW), .IDW(IDW)) u_sel (
      .cand(pd_q & en_q), .prio_flat(prio_flat),
      .found(found), .win_id(win_id), .win_prio(win_prio)
   );

   intc_nest_stack #(.DEPTH(DEPTH), .IDW(IDW), .PW(PW), .CW(CW)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push(ack_ok), .push_id(win_id), .push_prio(win_prio),
      .pop(irq_done), .depth(act_depth), .top_prio(act_prio)
   );

   // offer only when idle or strictly above the innermost active level
   assign irq_valid = found && ((act_depth == '0) || (win_prio < act_prio));
   assign irq_id    = win_id;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_EN_SET, A_EN_CLR: reg_rdata[N-1:0] = en_q;
         A_PD_SET, A_PD_CLR: reg_rdata[N-1:0] = pd_q;
         default: begin
            for (int k = 0; k < NWORDS; k++)
               if (reg_addr == AW'(32'(A_PRIO0) + k))
                  reg_rdata = prio_words[k*DW +: DW];
         end
      endcase
   end
endmodule

// File: rtl/intc_checks.sv
module intc_checks #(
   parameter int unsigned N   = 32,
   parameter int unsigned PW  = 2,
   parameter int unsigned IDW = 5,
   parameter int unsigned CW  = 3,
   parameter int unsigned AW  = 4,
   parameter int unsigned DW  = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N-1:0]   irq_req,
   input logic [N-1:0]   pd_q,
   input logic [N-1:0]   en_q,
   input logic [N-1:0]   clr_all,
   input logic           irq_valid,
   input logic [IDW-1:0] irq_id,
   input logic           irq_ack,
   input logic           irq_done,
   input logic [PW-1:0]  sel_prio,
   input logic [PW-1:0]  act_prio,
   input logic [CW-1:0]  act_depth,
   input logic [AW-1:0]  reg_addr,
   input logic [DW-1:0]  reg_rdata
);
   // R1: a request leaves its pending bit set unless cleared that edge
   p_req_pends_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_req) |=> ((($past(irq_req) & ~$past(clr_all)) & ~pd_q) == '0));

   // R5: the offered line is pending and enabled
   p_offer_cand_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (pd_q[irq_id] && en_q[irq_id]));

   // R7: acknowledge drops the pending bit of the offered line
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid && !irq_req[irq_id]) |=> !pd_q[$past(irq_id)]);

   // R8: only a strictly better level is offered during a handler
   p_strict_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && act_depth != '0) |-> (sel_prio < act_prio));

   // R9: retire shrinks the nesting by one
   p_retire_pops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done && act_depth != '0 && !(irq_ack && irq_valid))
      |=> act_depth == $past(act_depth) - CW'(1));

   // R8: nesting never exceeds the number of levels
   p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      act_depth <= CW'(1 << PW));

   // R4: reserved priority bits read zero
   p_prio_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr >= AW'(8)) |-> ((reg_rdata & 32'h3F3F_3F3F) == '0));
endmodule

bind intc_top intc_checks #(
   .N(N), .PW(PW), .IDW(IDW), .CW(CW), .AW(AW), .DW(DW)
) u_checks (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
   .pd_q(pd_q), .en_q(en_q), .clr_all(pd_clr | ack_mask),
   .irq_valid(irq_valid), .irq_id(irq_id),
   .irq_ack(irq_ack), .irq_done(irq_done),
   .sel_prio(win_prio), .act_prio(act_prio), .act_depth(act_depth),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/intc_top_test.sv
module intc_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_req = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_valid;
   logic [4:0]  irq_id;
   logic        irq_ack = 1'b0;
   logic        irq_done = 1'b0;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   intc_top uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_id(irq_id),
      .irq_ack(irq_ack), .irq_done(irq_done)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [31:0] m);
      @(negedge clk); irq_req = m;
      @(negedge clk); irq_req = '0;
      #1;
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      #1;
   endtask

   task automatic done();
      @(negedge clk); irq_done = 1'b1;
      @(negedge clk); irq_done = 1'b0;
      #1;
   endtask

   task automatic expect_offer(input string tag, input logic v, input logic [4:0] id);
      check({tag, " valid"}, 32'(irq_valid), 32'(v));
      if (v) check({tag, " id"}, 32'(irq_id), 32'(id));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         check("R11 reset readback", d, 32'h0);
      end
      expect_offer("R11 reset", 1'b0, 5'd0);
   endtask

   task automatic t_pending_regs();
      logic [31:0] d;
      wr(4'd2, 32'h0000_00A5);
      rd(4'd2, d); check("R2 set-pending", d, 32'h0000_00A5);
      rd(4'd3, d); check("R1 pending via clear addr", d, 32'h0000_00A5);
      wr(4'd3, 32'h0000_0005);
      rd(4'd2, d); check("R2 clear-pending", d, 32'h0000_00A0);
      wr(4'd3, 32'h0);
      rd(4'd2, d); check("R2 zero write ignored", d, 32'h0000_00A0);
      expect_offer("R5 pending but disabled", 1'b0, 5'd0);
      pulse(32'h0001_0000);
      rd(4'd2, d); check("R1 request pends", d, 32'h0001_00A0);
      wr(4'd3, 32'hFFFF_FFFF);
      rd(4'd2, d); check("R2 clear all", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(4'd0, 32'h0000_000F);
      wr(4'd0, 32'h0000_0030);
      rd(4'd0, d); check("R3 enable set", d, 32'h0000_003F);
      wr(4'd1, 32'h0000_0003);
      rd(4'd1, d); check("R3 enable clear", d, 32'h0000_003C);
      wr(4'd1, 32'h0);
      wr(4'd0, 32'h0);
      rd(4'd0, d); check("R3 zero writes ignored", d, 32'h0000_003C);
   endtask

   task automatic t_prio();
      logic [31:0] d;
      wr(4'd9, 32'hFFFF_FFFF);
      rd(4'd9, d); check("R4 reserved bits drop", d, 32'hC0C0_C0C0);
      wr(4'd9, 32'h8040_C000);
      rd(4'd9, d); check("R4 field placement", d, 32'h8040_C000);
      for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'hC0C0_C0C0);
      wr(4'd10, 32'hC0C0_80C0);   // line 9 -> level 2
      wr(4'd13, 32'hC0C0_C040);   // line 20 -> level 1
      wr(4'd9,  32'h00C0_C0C0);   // line 7 -> level 0
      rd(4'd13, d); check("R4 word 5", d, 32'hC0C0_C040);
      wr(4'd0, 32'hFFFF_FFFF);
   endtask

   task automatic t_arbitrate();
      logic [31:0] d;
      pulse(32'h0000_0208);                    // lines 3 and 9
      expect_offer("R5 best level", 1'b1, 5'd9);
      pulse(32'h0010_0000);                    // line 20 arrives late
      expect_offer("R6 late arrival", 1'b1, 5'd20);
      ack();
      rd(4'd2, d); check("R7 ack clears pending", d, 32'h0000_0208);
      expect_offer("R8 lower level blocked", 1'b0, 5'd0);
      pulse(32'h0000_0080);                    // line 7, level 0
      expect_offer("R8 strict preempt", 1'b1, 5'd7);
      ack();
      expect_offer("R8 nested hold", 1'b0, 5'd0);
      done();
      expect_offer("R9 resume outer", 1'b0, 5'd0);
      done();
      expect_offer("R9 idle offers", 1'b1, 5'd9);
      ack();
      expect_offer("R8 level 3 under 2", 1'b0, 5'd0);
      done();
      expect_offer("R9 next line", 1'b1, 5'd3);
      ack(); done();
      expect_offer("R9 all served", 1'b0, 5'd0);
      pulse(32'h0002_1000);                    // lines 12 and 17 tie
      expect_offer("R5 tie lower index", 1'b1, 5'd12);
      ack();
      expect_offer("R8 equal level no preempt", 1'b0, 5'd0);
      done();
      expect_offer("R9 tie second", 1'b1, 5'd17);
      ack(); done();
      expect_offer("R9 empty", 1'b0, 5'd0);
   endtask

   task automatic t_masked_and_stray();
      logic [31:0] d;
      wr(4'd1, 32'h0200_0000);
      pulse(32'h0200_0000);                    // line 25 disabled
      rd(4'd2, d); check("R5 disabled still pends", d, 32'h0200_0000);
      expect_offer("R5 disabled not offered", 1'b0, 5'd0);
      ack();                                   // ack with nothing offered
      rd(4'd2, d); check("R7 stray ack ignored", d, 32'h0200_0000);
      wr(4'd0, 32'h0200_0000);
      #1;
      expect_offer("R5 enabled now offered", 1'b1, 5'd25);
      ack(); done();
      expect_offer("R9 stray ack left no handler", 1'b0, 5'd0);
   endtask

   task automatic t_held();
      logic [31:0] d;
      @(negedge clk); irq_req = 32'h4000_0000;
      @(negedge clk);
      wr(4'd3, 32'h4000_0000);
      rd(4'd2, d); check("R10 cleared while held", d, 32'h0);
      @(negedge clk); #1;
      rd(4'd2, d); check("R10 re-pends next edge", d, 32'h4000_0000);
      irq_req = '0;
      wr(4'd3, 32'h4000_0000);
      rd(4'd2, d); check("R10 final clear", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_pending_regs();
      t_enable();
      t_prio();
      t_arbitrate();
      t_masked_and_stray();
      t_held();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule